// File: doc/BRIEF.md
# Privilege Level Access Checker

This block holds the current privilege level of the executing code and decides, in the same cycle as a request, whether that request may go ahead. Four kinds of request arrive on one port: a data segment access, a direct procedure call, a control transfer through a gate, and a return from such a transfer. Each request carries the privilege level of its target descriptor. Data and call requests can also carry the user/supervisor and read/write bits of the page they touch. There are four levels, 0 to 3, and level 0 is the most trusted.

Segment rules are checked first. A denied segment rule reports a general-protection class. If the segment rules pass and paging is on, the page bits are checked next, and a denial there reports a page-fault class. Levels 0 to 2 count as supervisor. The current level changes only through gates and returns. An accepted gate to a different level saves the old level on a small stack of depth `NEST_DEPTH` and loads the target level. A return pops the stack and restores the saved level. Descriptor fetch and gate decoding happen outside this block.

Top module: `priv_access_checker`

## Requirements
- R1: After reset, `cur_level_o` equals `RESET_LEVEL` (default 3) and the saved-level stack is empty.
- R2: A data request (kind 0) is allowed when the current level is numerically at most the target level. Otherwise it is denied with fault class 1 (general protection).
- R3: A direct call (kind 1) is allowed when the current level is numerically at least the target level. Otherwise it is denied with fault class 1. A direct call never changes the current level.
- R4: With `paging_on_i` high, a data or call request made at level 3 is denied with fault class 2 (page fault) in either of two cases: the page is supervisor-only (`pg_user_i` = 0), or `wr_i` = 1 and the page is read-only (`pg_writable_i` = 0). At levels 0 to 2, and whenever paging is off, the page bits have no effect.
- R5: When a request breaks both a segment rule and a page rule, the reported fault class is 1.
- R6: A gate request (kind 2) whose target level is numerically at most the current level is allowed. If the target level differs from the current level, the current level becomes the target level on the next clock and the old level is saved. A gate to the same level changes nothing and saves nothing.
- R7: A gate request whose target level is numerically greater than the current level is denied with fault class 1, and the current level stays the same.
- R8: A return (kind 3) restores the most recently saved level on the next clock. Saved levels come back in last-in, first-out order.
- R9: A return with no saved level is denied with fault class 1, and the current level stays the same.
- R10: A gate to a different level while `NEST_DEPTH` levels are already saved is denied with fault class 1, and the current level stays the same.
- R11: While `req_valid_i` is low, `allow_o` is 0, `fault_o` is 0 and the current level does not change, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | A request is present this cycle |
| req_kind_i | input | 2 | 0 data, 1 direct call, 2 gate, 3 return |
| tgt_level_i | input | 2 | Privilege level of the target descriptor |
| paging_on_i | input | 1 | Page checks enabled |
| pg_user_i | input | 1 | Page is accessible from level 3 |
| pg_writable_i | input | 1 | Page may be written |
| wr_i | input | 1 | The access is a write |
| allow_o | output | 1 | Request accepted |
| fault_o | output | 2 | 0 none, 1 general protection, 2 page fault |
| cur_level_o | output | 2 | Current privilege level |

## Verification
The bench walks the current level inward through gates until the stack is full, and then back out through returns. A design that swapped the push and pop order would come back to the wrong ring. A design that ignored the full stack would silently lose a saved level. The bench also sends requests that break both a segment rule and a page rule, to catch a design that gives page faults priority. It checks pages marked supervisor-only and read-only at levels 0 to 2 and with paging off, where they must pass, to catch a page check that ignores the level or the paging enable. Gates to the same level must leave the stack untouched. A design that pushed on them would give the wrong result on a later return, or would refuse with the stack wrongly full.

// File: rtl/priv_pkg.sv
package priv_pkg;
  localparam int unsigned LEVEL_W = 2;
  typedef logic [LEVEL_W-1:0] level_t;
  localparam level_t LEVEL_USER = level_t'(3);

  typedef enum logic [1:0] {
    REQ_DATA = 2'd0,
    REQ_CALL = 2'd1,
    REQ_GATE = 2'd2,
    REQ_RET  = 2'd3
  } req_kind_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_GP   = 2'd1,
    FLT_PF   = 2'd2
  } fault_e;
endpackage

// File: rtl/priv_seg_rule.sv
module priv_seg_rule
  import priv_pkg::*;
(
  input  req_kind_e kind_i,
  input  level_t    cur_i,
  input  level_t    tgt_i,
  input  logic      stk_empty_i,
  input  logic      stk_full_i,
  output logic      seg_ok_o
);
  always_comb begin
    unique case (kind_i)
      REQ_DATA: seg_ok_o = (cur_i <= tgt_i);
      REQ_CALL: seg_ok_o = (cur_i >= tgt_i);
      // inward only; a level change needs room to save the old level
      REQ_GATE: seg_ok_o = (tgt_i <= cur_i) && ((tgt_i == cur_i) || !stk_full_i);
      REQ_RET:  seg_ok_o = !stk_empty_i;
      default:  seg_ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/priv_page_rule.sv
module priv_page_rule
  import priv_pkg::*;
(
  input  logic   applies_i,
  input  level_t cur_i,
  input  logic   user_i,
  input  logic   writable_i,
  input  logic   wr_i,
  output logic   page_ok_o
);
  logic is_user;
  logic bad_user, bad_write;

  assign is_user   = (cur_i == LEVEL_USER);
  assign bad_user  = !user_i;
  assign bad_write = wr_i && !writable_i;
  assign page_ok_o = !(applies_i && is_user && (bad_user || bad_write));
endmodule

// File: rtl/priv_level_stack.sv
module priv_level_stack
  import priv_pkg::*;
#(
  parameter int unsigned DEPTH       = 3,
  parameter int unsigned RESET_LEVEL = 3
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   enter_i,
  input  level_t enter_lvl_i,
  input  logic   leave_i,
  output level_t cur_o,
  output logic   empty_o,
  output logic   full_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH + 1);

  level_t           cur_q;
  logic [PTR_W-1:0] cnt_q;
  level_t           slot_q [DEPTH];
  level_t           top;

  assign cur_o   = cur_q;
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == PTR_W'(DEPTH));

  always_comb begin
    top = level_t'(RESET_LEVEL);
    for (int i = 0; i < int'(DEPTH); i++) begin
      if (cnt_q == PTR_W'(i + 1)) top = slot_q[i];
    end
  end

  for (genvar g = 0; g < int'(DEPTH); g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    slot_q[g] <= '0;
      else if (enter_i && (cnt_q == PTR_W'(g)))       slot_q[g] <= cur_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= level_t'(RESET_LEVEL);
      cnt_q <= '0;
    end else if (enter_i) begin
      cur_q <= enter_lvl_i;
      cnt_q <= cnt_q + PTR_W'(1);
    end else if (leave_i) begin
      cur_q <= top;
      cnt_q <= cnt_q - PTR_W'(1);
    end
  end
endmodule

// File: rtl/priv_access_checker.sv
module priv_access_checker
  import priv_pkg::*;
#(
  parameter int unsigned NEST_DEPTH  = 3,
  parameter int unsigned RESET_LEVEL = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  input  logic [1:0] req_kind_i,
  input  logic [1:0] tgt_level_i,
  input  logic       paging_on_i,
  input  logic       pg_user_i,
  input  logic       pg_writable_i,
  input  logic       wr_i,
  output logic       allow_o,
  output logic [1:0] fault_o,
  output logic [1:0] cur_level_o
);
  req_kind_e kind;
  level_t    cur, tgt;
  logic      stk_empty, stk_full;
  logic      seg_ok, page_ok, pg_applies;
  fault_e    fault;
  logic      enter, leave;

  assign kind       = req_kind_e'(req_kind_i);
  assign tgt        = level_t'(tgt_level_i);
  assign pg_applies = paging_on_i && ((kind == REQ_DATA) || (kind == REQ_CALL));

  priv_seg_rule u_seg (
    .kind_i      (kind),
    .cur_i       (cur),
    .tgt_i       (tgt),
    .stk_empty_i (stk_empty),
    .stk_full_i  (stk_full),
    .seg_ok_o    (seg_ok)
  );

  priv_page_rule u_page (
    .applies_i  (pg_applies),
    .cur_i      (cur),
    .user_i     (pg_user_i),
    .writable_i (pg_writable_i),
    .wr_i       (wr_i),
    .page_ok_o  (page_ok)
  );

  // segment fault outranks page fault
  always_comb begin
    if (!req_valid_i)  fault = FLT_NONE;
    else if (!seg_ok)  fault = FLT_GP;
    else if (!page_ok) fault = FLT_PF;
    else               fault = FLT_NONE;
  end

  assign allow_o = req_valid_i && (fault == FLT_NONE);
  assign fault_o = fault;
  assign enter   = allow_o && (kind == REQ_GATE) && (tgt != cur);
  assign leave   = allow_o && (kind == REQ_RET);

  priv_level_stack #(
    .DEPTH       (NEST_DEPTH),
    .RESET_LEVEL (RESET_LEVEL)
  ) u_stack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enter_i     (enter),
    .enter_lvl_i (tgt),
    .leave_i     (leave),
    .cur_o       (cur),
    .empty_o     (stk_empty),
    .full_o      (stk_full)
  );

  assign cur_level_o = cur;
endmodule

// File: rtl/priv_access_props.sv
module priv_access_props (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic [1:0] req_kind_i,
  input logic [1:0] tgt_level_i,
  input logic       allow_o,
  input logic [1:0] fault_o,
  input logic [1:0] cur_level_o
);
  assert_idle_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> (!allow_o && fault_o == 2'd0));

  assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> $stable(cur_level_o));

  assert_data_outward_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_kind_i == 2'd0 && cur_level_o > tgt_level_i) |-> (fault_o == 2'd1));

  assert_call_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_kind_i == 2'd1) |=> $stable(cur_level_o));

  assert_pf_only_user_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o == 2'd2) |-> (cur_level_o == 2'd3));

  assert_gate_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (allow_o && req_kind_i == 2'd2) |=> (cur_level_o == $past(tgt_level_i)));

  assert_deny_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !allow_o) |=> $stable(cur_level_o));

  assert_allow_clean_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    allow_o |-> (fault_o == 2'd0));
endmodule

bind priv_access_checker priv_access_props u_props (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_kind_i  (req_kind_i),
  .tgt_level_i (tgt_level_i),
  .allow_o     (allow_o),
  .fault_o     (fault_o),
  .cur_level_o (cur_level_o)
);

// File: tb/sim_priv_access_checker.sv
`timescale 1ns/1ps
module sim_priv_access_checker;
  localparam int DEPTH = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vld = 1'b0;
  logic [1:0] kind = 2'd0, tgt = 2'd0;
  logic       pg_on = 1'b0, pg_usr = 1'b1, pg_wr = 1'b1, wr = 1'b0;
  logic       allow;
  logic [1:0] fault, cur;

  always #2 clk = ~clk;

  priv_access_checker #(.NEST_DEPTH(DEPTH), .RESET_LEVEL(3)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(vld), .req_kind_i(kind),
    .tgt_level_i(tgt), .paging_on_i(pg_on), .pg_user_i(pg_usr),
    .pg_writable_i(pg_wr), .wr_i(wr), .allow_o(allow), .fault_o(fault),
    .cur_level_o(cur)
  );

  typedef struct {
    logic       allow;
    logic [1:0] fault;
    logic [1:0] cur;
    string      tag;
  } item_t;

  item_t sb_q[$];
  int    checks = 0, errors = 0;
  int    m_cur = 3;
  int    m_stk[$];
  bit    done = 0;

  task automatic push_exp(input logic a, input logic [1:0] f, input string tag);
    item_t it;
    it.allow = a; it.fault = f; it.cur = 2'(m_cur); it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic req(input int k, input int t, input bit pon, input bit usr,
                     input bit wbl, input bit w, input string tag);
    bit gp, pf;
    int f;
    @(negedge clk);
    vld = 1'b1; kind = 2'(k); tgt = 2'(t); pg_on = pon; pg_usr = usr; pg_wr = wbl; wr = w;
    case (k)
      0: gp = m_cur > t;
      1: gp = m_cur < t;
      2: gp = (t > m_cur) || (t != m_cur && m_stk.size() == DEPTH);
      default: gp = m_stk.size() == 0;
    endcase
    pf = (k <= 1) && pon && m_cur == 3 && (!usr || (w && !wbl));
    f  = gp ? 1 : (pf ? 2 : 0);
    push_exp(f == 0, 2'(f), tag);
    if (f == 0 && k == 2 && t != m_cur) begin m_stk.push_back(m_cur); m_cur = t; end
    if (f == 0 && k == 3) m_cur = m_stk.pop_back();
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    vld = 1'b0; kind = 2'd2; tgt = 2'd0; pg_on = 1'b1; pg_usr = 1'b0; wr = 1'b1;
    push_exp(1'b0, 2'd0, tag);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      #1;
      if (sb_q.size() != 0) begin
        it = sb_q.pop_front();
        checks++;
        if (allow !== it.allow || fault !== it.fault || cur !== it.cur) begin
          errors++;
          $display("FAIL %s: got allow=%0d fault=%0d cur=%0d exp allow=%0d fault=%0d cur=%0d",
                   it.tag, allow, fault, cur, it.allow, it.fault, it.cur);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle("R1 reset level");
    req(3, 0, 0, 1, 1, 0, "R9 return empty after reset R1");
    for (int t = 0; t < 4; t++) req(0, t, 0, 1, 1, 0, "R2 data sweep at level 3");
    req(1, 0, 0, 1, 1, 0, "R3 call inward keeps level");
    idle("R3 level unchanged after call");
    req(0, 3, 1, 0, 1, 0, "R4 supervisor page at level 3");
    req(0, 3, 1, 1, 0, 1, "R4 write read-only page at level 3");
    req(0, 3, 1, 1, 0, 0, "R4 read read-only page at level 3");
    req(0, 3, 0, 0, 0, 1, "R4 paging off ignores page bits");
    req(0, 2, 1, 0, 0, 1, "R5 gp beats pf");
    req(1, 2, 1, 0, 1, 0, "R4 call to supervisor page at level 3");
    req(2, 3, 0, 1, 1, 0, "R6 same-level gate");
    req(2, 2, 0, 1, 1, 0, "R6 gate to 2");
    req(1, 3, 0, 1, 1, 0, "R3 call outward denied");
    req(0, 3, 1, 0, 0, 1, "R4 page bits ignored at level 2");
    req(2, 3, 0, 1, 1, 0, "R7 outward gate denied");
    req(2, 1, 0, 1, 1, 0, "R6 gate to 1");
    req(2, 1, 0, 1, 1, 0, "R6 same-level gate while full");
    req(2, 0, 0, 1, 1, 0, "R10 gate with stack full");
    for (int t = 0; t < 4; t++) req(0, t, 1, 0, 0, 1, "R2 data sweep at level 1");
    idle("R11 idle with noisy inputs");
    req(3, 0, 0, 1, 1, 0, "R8 return to 2");
    req(3, 0, 0, 1, 1, 0, "R8 return to 3");
    req(3, 0, 0, 1, 1, 0, "R9 return with stack empty");
    req(2, 0, 0, 1, 1, 0, "R6 gate 3 to 0");
    req(0, 3, 1, 0, 0, 1, "R4 page bits ignored at level 0");
    req(3, 0, 0, 1, 1, 0, "R8 return 0 to 3");
    idle("R11 final level");
    wait (sb_q.size() == 0);
    @(negedge clk); #2;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule